// File: doc/BRIEF.md
# Reloadable Watchdog Counter with Sticky Overflow Flag

This block is a software-controlled watchdog. Firmware programs a reload value, starts the counter and must keep requesting refreshes. Each refresh loads the counter from the reload value. While running, the counter advances by one on every clock in which the prescaled `tick` input is high. If it passes its all-ones value, the block raises `rst_req` for a fixed number of clocks so that the chip's reset sequencer can reset the system.

A value written to the reload register is only a staging copy. The counter takes it up at the next refresh and not before. This includes the automatic reload that follows a reset pulse, which reuses the value captured at the last refresh. A status flag records every overflow. The system reset that the watchdog itself causes (`sys_rst_n`) does not clear this flag, so firmware can tell why it restarted. Firmware clears the flag by writing 1 to it. Only the power-on reset (`por_n`) clears everything.

The control path is a three-state machine:
- STOP: the counter holds.
- RUN: the counter advances on ticks.
- FIRE: the reset request is driven.

Its transitions are:
- STOP to RUN when the start bit is 1.
- RUN to STOP when the start bit is 0.
- RUN to FIRE on a tick with the counter at all ones and no refresh pending.
- FIRE stays in FIRE until the pulse counter reaches zero. It then goes to RUN if the start bit is 1, otherwise to STOP.

A pending refresh is serviced in STOP and RUN, and waits in FIRE.

Top module: `watchdog_unit`

## Requirements
- R1: After `por_n` is low at a clock edge, the control register (address 0) and the reload register (address 1) both read 0, and `rst_req` is low.
- R2: The control register has a start bit at bit 0. Writing it 1 lets the counter advance on ticks. Writing it 0 freezes the counter, and no number of ticks then causes an overflow. Setting it to 1 again resumes counting from the frozen value.
- R3: Writing 1 to control bit 1 requests a refresh. The bit reads 1 in the cycle after the write edge. Hardware clears it at the next edge, at which point the counter is loaded from the reload register.
- R4: A write to the reload register (address 1) does not change the count in progress, nor the value reloaded after a reset pulse. Only the next refresh picks it up.
- R5: After a refresh loads value V, `rst_req` rises after exactly 2^CNT_W − V further tick edges, because overflow happens on a tick when the counter is all ones.
- R6: On overflow, `rst_req` is high for exactly PULSE_CYCLES consecutive clocks. The counter is then reloaded with the value captured at the last refresh, and counting resumes if the start bit is still 1.
- R7: Overflow sets control bit 2 (the status flag). Holding `sys_rst_n` low clears the start bit, the refresh bit, the reload register and the counter, but leaves the flag set.
- R8: Writing 1 to control bit 2 clears the flag, and writing 0 there leaves it unchanged. An overflow in the same cycle as a clear wins.
- R9: `por_n` low clears the status flag together with every other register.
- R10: A refresh serviced on the same edge as a tick at the all-ones count reloads the counter instead of overflowing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous; clears all state |
| sys_rst_n | input | 1 | System reset, active low, synchronous; keeps the status flag |
| tick | input | 1 | Prescaled time base, one count per high cycle |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W (2) | Register select: 0 control, 1 reload |
| wdata | input | CNT_W (8) | Write data |
| rdata | output | CNT_W (8) | Read data for `addr`, combinational |
| rst_req | output | 1 | Reset request, high during the pulse |

## Verification
The hardest case to reach from the ports is a refresh landing on exactly the edge where a tick would overflow an all-ones count. The bench reaches it with reload value 0xFE and tick held high. It counts edges from a refresh so that a second refresh write lands on the overflow edge, and then checks that `rst_req` stays low for the following two edges. Surviving the self-caused reset is exercised by letting the overflow happen and pulling `sys_rst_n` low while `rst_req` is high, as a sequencer would. The bench then reads the flag back.

// File: rtl/wd_pkg.sv
package wd_pkg;
    typedef enum logic [1:0] {
        WD_STOP = 2'd0,
        WD_RUN  = 2'd1,
        WD_FIRE = 2'd2
    } wd_state_t;

    localparam int CTRL_ADDR   = 0;
    localparam int RELOAD_ADDR = 1;
    localparam int RUN_BIT     = 0;
    localparam int KICK_BIT    = 1;
    localparam int FLAG_BIT    = 2;
endpackage

// File: rtl/wd_regs.sv
module wd_regs
    import wd_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              kick_done_i,
    input  logic              ovf_i,
    input  logic              fire_i,
    output logic              run_o,
    output logic              kick_o,
    output logic [DATA_W-1:0] reload_o,
    output logic [DATA_W-1:0] rdata_o
);
    logic              run_q, kick_q, flag_q;
    logic [DATA_W-1:0] reload_q;
    logic              wr_ctrl, wr_reload;

    assign wr_ctrl   = wr_en_i && (addr_i == ADDR_W'(CTRL_ADDR));
    assign wr_reload = wr_en_i && (addr_i == ADDR_W'(RELOAD_ADDR));

    // start bit, refresh request and staging reload value: both resets
    always_ff @(posedge clk) begin
        if (!por_n || !sys_rst_n) begin
            run_q    <= 1'b0;
            kick_q   <= 1'b0;
            reload_q <= '0;
        end else begin
            if (wr_ctrl) run_q <= wdata_i[RUN_BIT];
            kick_q <= (wr_ctrl && wdata_i[KICK_BIT]) || (kick_q && !kick_done_i);
            if (wr_reload) reload_q <= wdata_i;
        end
    end

    // status flag: power-on reset only, set beats clear
    always_ff @(posedge clk) begin
        if (!por_n)                            flag_q <= 1'b0;
        else if (ovf_i)                        flag_q <= 1'b1;
        else if (wr_ctrl && wdata_i[FLAG_BIT]) flag_q <= 1'b0;
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_W'(CTRL_ADDR)) begin
            rdata_o[RUN_BIT]  = run_q;
            rdata_o[KICK_BIT] = kick_q;
            rdata_o[FLAG_BIT] = flag_q;
        end else if (addr_i == ADDR_W'(RELOAD_ADDR)) begin
            rdata_o = reload_q;
        end
    end

    assign run_o    = run_q;
    assign kick_o   = kick_q;
    assign reload_o = reload_q;

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        (flag_q && !(wr_ctrl && wdata_i[FLAG_BIT])) |=> flag_q); // R7
    AST_OVF_SETS_FLAG: assert property (@(posedge clk) disable iff (!por_n)
        ovf_i |=> flag_q); // R8
    AST_KICK_SELF_CLEAR: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        (kick_q && !fire_i && !(wr_ctrl && wdata_i[KICK_BIT])) |=> !kick_q); // R3
endmodule

// File: rtl/wd_fsm.sv
module wd_fsm
    import wd_pkg::*;
#(
    parameter int CNT_W        = 8,
    parameter int PULSE_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             run_i,
    input  logic             kick_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic             kick_done_o,
    output logic             ovf_o,
    output logic             fire_o
);
    localparam int PW = $clog2(PULSE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX   = '1;
    localparam logic [PW-1:0]    PULSE_TOP = PW'(PULSE_CYCLES - 1);

    wd_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, act_q;
    logic [PW-1:0]    pul_q;
    logic             inc, pulse_end, at_max;

    assign at_max    = (cnt_q == CNT_MAX);
    assign pulse_end = (pul_q == '0);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WD_STOP;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_STOP: if (run_i) state_d = WD_RUN;
            WD_RUN: begin
                if (!run_i)                              state_d = WD_STOP;
                else if (tick_i && !kick_i && at_max)    state_d = WD_FIRE;
            end
            WD_FIRE: if (pulse_end) state_d = run_i ? WD_RUN : WD_STOP;
            default: state_d = WD_STOP;
        endcase
    end

    // outputs
    always_comb begin
        kick_done_o = kick_i && (state_q != WD_FIRE);
        ovf_o       = (state_q == WD_RUN) && (state_d == WD_FIRE);
        fire_o      = (state_q == WD_FIRE);
        inc         = (state_q == WD_RUN) && run_i && tick_i && !kick_i && !at_max;
    end

    // counter, refresh-captured reload value, pulse timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            act_q <= '0;
            pul_q <= '0;
        end else begin
            if (kick_done_o) begin
                cnt_q <= reload_i;
                act_q <= reload_i;
            end else if (inc) begin
                cnt_q <= cnt_q + 1'b1;
            end else if (fire_o && pulse_end) begin
                cnt_q <= act_q;
            end
            if (ovf_o)                    pul_q <= PULSE_TOP;
            else if (fire_o && !pulse_end) pul_q <= pul_q - 1'b1;
        end
    end

    AST_FIRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_FIRE && pul_q != '0) |=> (state_q == WD_FIRE)); // R6
    AST_FIRE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fire_o) |-> (pul_q == PULSE_TOP)); // R6
    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_STOP && !kick_i) |=> (cnt_q == $past(cnt_q))); // R2
    AST_REFRESH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (kick_i && state_q != WD_FIRE) |=> (cnt_q == $past(reload_i) && !fire_o)); // R10
endmodule

// File: rtl/watchdog_unit.sv
module watchdog_unit #(
    parameter int CNT_W        = 8,
    parameter int PULSE_CYCLES = 4,
    parameter int ADDR_W       = 2
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    output logic              rst_req
);
    logic             run, kick, kick_done, ovf, fire, core_rst_n;
    logic [CNT_W-1:0] reload;

    assign core_rst_n = por_n && sys_rst_n;
    assign rst_req    = fire;

    wd_regs #(.DATA_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
        .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
        .kick_done_i(kick_done), .ovf_i(ovf), .fire_i(fire),
        .run_o(run), .kick_o(kick), .reload_o(reload), .rdata_o(rdata)
    );

    wd_fsm #(.CNT_W(CNT_W), .PULSE_CYCLES(PULSE_CYCLES)) u_fsm (
        .clk(clk), .rst_n(core_rst_n), .tick_i(tick),
        .run_i(run), .kick_i(kick), .reload_i(reload),
        .kick_done_o(kick_done), .ovf_o(ovf), .fire_o(fire)
    );

    AST_POR_QUIET: assert property (@(posedge clk) !por_n |=> !rst_req); // R1
endmodule

// File: tb/sim_watchdog_unit.sv
`timescale 1ns/1ps
module sim_watchdog_unit;
    localparam int W = 8;
    localparam int PULSE = 4;
    localparam int MAXV = (1 << W) - 1;

    logic clk = 1'b0;
    logic por_n = 1'b0, sys_rst_n = 1'b0, tick = 1'b1, wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata;
    logic rst_req;

    int errors = 0, checks = 0;
    bit cmp_en = 1'b0, finished = 1'b0;

    always #2 clk = ~clk;

    watchdog_unit u0 (.clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .tick(tick),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .rst_req(rst_req));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference: 0 stopped, 1 counting, 2 firing
    int m_st = 0, m_cnt = 0, m_act = 0, m_pul = 0, m_reload = 0;
    bit m_run = 0, m_kick = 0, m_flag = 0;

    always @(posedge clk) begin
        bit done, ovf, wc;
        int nst;
        if (!por_n) begin
            m_st = 0; m_cnt = 0; m_act = 0; m_pul = 0; m_reload = 0;
            m_run = 0; m_kick = 0; m_flag = 0;
        end else if (!sys_rst_n) begin
            m_st = 0; m_cnt = 0; m_act = 0; m_pul = 0; m_reload = 0;
            m_run = 0; m_kick = 0;
        end else begin
            done = m_kick && (m_st != 2);
            ovf = 0;
            nst = m_st;
            if (done) begin m_cnt = m_reload; m_act = m_reload; end
            if (m_st == 0) begin
                if (m_run) nst = 1;
            end else if (m_st == 1) begin
                if (!m_run) nst = 0;
                else if (tick && !m_kick) begin
                    if (m_cnt == MAXV) begin ovf = 1; nst = 2; m_pul = PULSE - 1; end
                    else m_cnt = m_cnt + 1;
                end
            end else begin
                if (m_pul == 0) begin m_cnt = m_act; nst = m_run ? 1 : 0; end
                else m_pul = m_pul - 1;
            end
            wc = wr_en && (addr == 2'd0);
            if (wc) m_run = wdata[0];
            m_kick = (wc && wdata[1]) || (m_kick && !done);
            if (ovf) m_flag = 1;
            else if (wc && wdata[2]) m_flag = 0;
            if (wr_en && addr == 2'd1) m_reload = int'(wdata);
            m_st = nst;
        end
    end

    always @(negedge clk) begin
        int exp_rd;
        #1.5;
        if (cmp_en) begin
            exp_rd = (addr == 2'd0) ? (int'(m_flag) * 4 + int'(m_kick) * 2 + int'(m_run)) :
                     (addr == 2'd1) ? m_reload : 0;
            chk(rst_req == (m_st == 2), "R6 model rst_req", int'(rst_req), int'(m_st == 2));
            chk(int'(rdata) == exp_rd, "R5 model rdata", int'(rdata), exp_rd);
        end
    end

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        addr = a; #0.25; v = int'(rdata);
    endtask

    task automatic edges_to_req(output int n);
        n = 0;
        while (!rst_req && n < 2000) begin cyc(); n++; end
    endtask

    task automatic pulse_len(output int n);
        n = 0;
        while (rst_req && n < 100) begin n++; cyc(); end
    endtask

    initial begin
        int v, n, highs;
        repeat (3) cyc();
        por_n = 1'b1; sys_rst_n = 1'b1;
        rd(2'd0, v); chk(v == 0, "R1 ctrl after por", v, 0);
        rd(2'd1, v); chk(v == 0, "R1 reload after por", v, 0);
        chk(rst_req == 1'b0, "R1 rst_req after por", int'(rst_req), 0);
        cmp_en = 1'b1;

        // first refresh with 0xF0, timing and pulse
        wr(2'd1, 8'hF0);
        rd(2'd1, v); chk(v == 8'hF0, "R4 reload readback", v, 8'hF0);
        wr(2'd0, 8'h03);
        rd(2'd0, v); chk(v == 3, "R3 refresh bit visible", v, 3);
        cyc();
        rd(2'd0, v); chk(v == 1, "R3 refresh bit cleared", v, 1);
        edges_to_req(n); chk(n == 16, "R5 ticks to overflow from 0xF0", n, 16);
        rd(2'd0, v); chk(v == 5, "R7 flag set on overflow", v, 5);
        pulse_len(n); chk(n == PULSE, "R6 pulse length", n, PULSE);

        // reload change without refresh
        wr(2'd1, 8'h80);
        edges_to_req(n); chk(n == 15, "R4 reload write ignored until refresh", n, 15);
        pulse_len(n); chk(n == PULSE, "R6 pulse length again", n, PULSE);

        // clear flag and refresh together: new value now used
        wr(2'd0, 8'h07);
        rd(2'd0, v); chk(v == 3, "R8 flag cleared by writing one", v, 3);
        edges_to_req(n); chk(n == 129, "R4 new reload after refresh", n, 129);

        // loop-back of the system reset while the request is high
        sys_rst_n = 1'b0; cyc(); cyc(); sys_rst_n = 1'b1;
        rd(2'd0, v); chk(v == 4, "R7 flag survives system reset", v, 4);
        rd(2'd1, v); chk(v == 0, "R7 reload cleared by system reset", v, 0);
        chk(rst_req == 1'b0, "R7 request dropped", int'(rst_req), 0);

        wr(2'd0, 8'h00);
        rd(2'd0, v); chk(v == 4, "R8 writing zero keeps flag", v, 4);
        wr(2'd0, 8'h04);
        rd(2'd0, v); chk(v == 0, "R8 writing one clears flag", v, 0);

        // stop freezes the count
        wr(2'd1, 8'hFE);
        wr(2'd0, 8'h03);
        wr(2'd0, 8'h00);
        highs = 0;
        for (int i = 0; i < 300; i++) begin cyc(); if (rst_req) highs++; end
        chk(highs == 0, "R2 no overflow while stopped", highs, 0);
        wr(2'd0, 8'h01);
        edges_to_req(n); chk(n == 3, "R2 resume from frozen count", n, 3);
        pulse_len(n);
        wr(2'd0, 8'h00);
        cyc(); cyc();

        // refresh on the overflow edge
        wr(2'd0, 8'h03);
        cyc();
        wr(2'd0, 8'h03);
        chk(rst_req == 1'b0, "R10 low before collision", int'(rst_req), 0);
        cyc(); chk(rst_req == 1'b0, "R10 refresh beats overflow", int'(rst_req), 0);
        cyc(); chk(rst_req == 1'b0, "R10 counting again", int'(rst_req), 0);
        cyc(); chk(rst_req == 1'b1, "R10 later overflow", int'(rst_req), 1);

        // irregular tick pattern, model-compared
        for (int i = 0; i < 600; i++) begin tick = (i % 3) != 1; cyc(); end
        tick = 1'b1;
        rd(2'd0, v); chk(v[2] == 1'b1, "R9 flag set before power-on reset", int'(v[2]), 1);

        por_n = 1'b0; cyc(); cyc(); por_n = 1'b1;
        rd(2'd0, v); chk(v == 0, "R9 power-on reset clears flag", v, 0);
        rd(2'd1, v); chk(v == 0, "R9 power-on reset clears reload", v, 0);
        cyc(); cyc();

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule